// File: doc/BRIEF.md
# Flash ECC Error Reporting Unit

This unit sits between the ECC checkers of a two-bank flash and the rest of the chip. Each flash read arrives as a strobe with a bank select, the read address and two checker outcomes: a single-bit error that the checker corrected, and a double-bit error that it could only detect. The unit records each error in a sticky two-bit field for the bank that was read. A per-severity configuration word decides whether the error is recorded at all, and whether it raises an interrupt or a bus-error response.

In interrupt mode the address and bank of the first failing read are captured for software. They stay held until software has cleared every read-error flag. In exception mode the unit returns a one-cycle bus-error response and loads a fault-address register with the failing address. Reads made while a signature command runs follow their own path. Their errors are collected silently and appear in a separate command-error field only when the command-complete strobe arrives. They never raise an interrupt or a bus error.

Top module: `fecc_report`

## Requirements
- R1: After reset, `status`, `irq`, `bus_err`, `err_addr`, `err_bank` and `fault_addr` are all zero.
- R2: A recorded read error sets the bank's field (bank 0 in `status[10:9]`, bank 1 in `status[12:11]`) the cycle after the strobe. The code is 01 for a corrected single-bit error and 10 for a double-bit error; when both checker flags are high the error counts as double-bit. A double-bit code is never downgraded by a later single-bit error, and a field never holds 11.
- R3: `cfg_mode[1:0]` selects reporting for single-bit errors and `cfg_mode[3:2]` for double-bit errors: 00 off, 01 interrupt, 10 exception, and 11 is treated as off. When the selected mode is off, the error leaves `status`, `irq` and `bus_err` unchanged.
- R4: An interrupt-mode error raises `irq` the next cycle. If `irq` was low, the same error loads `err_addr` and `err_bank`. While `irq` stays high, both hold the first captured error.
- R5: `irq` falls in the cycle after a status clear leaves both read-error fields at zero. A later interrupt-mode error then captures its own address.
- R6: An exception-mode error gives a `bus_err` pulse of exactly one cycle in the cycle after the read, and loads `fault_addr` with the read address. It does not raise `irq`.
- R7: A read with `rd_in_sig` high changes no bank field, `irq`, `bus_err` or address register, whatever `cfg_mode` holds. Its errors are held back. In the cycle after `cmd_done`, `status[8:7]` takes the merged code of the held errors and of any error on that same cycle, using the R2 encoding. Before `cmd_done`, the field does not change.
- R8: `status[12:7]` are write-1-to-clear through `clr_wr` and `clr_bits`. A set in the same cycle wins over a clear of the same field. All other status bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_vld | input | 1 | One flash read completed this cycle |
| rd_bank | input | 1 | Bank of the read |
| rd_addr | input | ADDR_W | Address of the read |
| rd_sec | input | 1 | Checker corrected a single-bit error |
| rd_ded | input | 1 | Checker detected a double-bit error |
| rd_in_sig | input | 1 | Read belongs to a signature command |
| cmd_done | input | 1 | Signature command completed |
| cfg_mode | input | 4 | Reporting mode per severity |
| clr_wr | input | 1 | Status clear write strobe |
| clr_bits | input | 13 | Write-1-to-clear mask |
| status | output | 13 | Status word |
| irq | output | 1 | Interrupt request |
| bus_err | output | 1 | Bus-error response for the failing read |
| err_addr | output | ADDR_W | Captured interrupt address |
| err_bank | output | 1 | Bank of the captured interrupt address |
| fault_addr | output | ADDR_W | Address of the last exception-mode error |

## Verification
The assertions check on every cycle that no field holds the illegal code 11 and that a double-bit code survives until its bit is cleared. They also check that signature reads raise no bus error, that the command-error field gains bits only on completion, that the captured interrupt address does not move while `irq` stays high, and that a fully disabled configuration leaves the bank fields untouched. Only the bench scenarios show the full mapping from configuration and severity to flags and outputs, the order in which severity override and first-address capture work, how a clear and a set in the same cycle interact, and how held signature errors merge at completion.

// File: rtl/fecc_pkg.sv
package fecc_pkg;

    localparam int STAT_W    = 13;
    localparam int CMD_LSB   = 7;
    localparam int BANK0_LSB = 9;
    localparam int BANK1_LSB = 11;
    localparam int NBANK     = 2;

    typedef enum logic [1:0] {
        SEV_NONE = 2'b00,
        SEV_SEC  = 2'b01,
        SEV_DED  = 2'b10
    } sev_e;

    typedef enum logic [1:0] {
        RPT_OFF = 2'b00,
        RPT_IRQ = 2'b01,
        RPT_EXC = 2'b10
    } rpt_e;

    // combine two severity codes: double-bit dominates single-bit
    function automatic logic [1:0] sev_merge(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] r;
        if (a == SEV_DED || b == SEV_DED)
            r = SEV_DED;
        else if (a == SEV_SEC || b == SEV_SEC)
            r = SEV_SEC;
        else
            r = SEV_NONE;
        return r;
    endfunction

endpackage

// File: rtl/fecc_bank_field.sv
module fecc_bank_field
    import fecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_vld,
    input  logic [1:0] set_sev,
    input  logic [1:0] clr_mask,
    output logic [1:0] field
);

    logic [1:0] field_d, field_q;

    always_comb begin
        field_d = field_q & ~clr_mask;
        if (set_vld)
            field_d = sev_merge(field_d, set_sev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            field_q <= SEV_NONE;
        else
            field_q <= field_d;
    end

    assign field = field_q;

    AST_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        field_q != 2'b11); // R2

    AST_DED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (field_q == SEV_DED && !clr_mask[1]) |=> field_q == SEV_DED); // R2

endmodule

// File: rtl/fecc_sig_track.sv
module fecc_sig_track
    import fecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_vld,
    input  logic [1:0] err_sev,
    input  logic       cmd_done,
    input  logic [1:0] clr_mask,
    output logic [1:0] cmd_field
);

    typedef struct packed {
        logic [1:0] pend;
        logic [1:0] field;
    } sig_st_t;

    sig_st_t st_d, st_q;
    logic [1:0] merged;

    always_comb begin
        merged     = sev_merge(st_q.pend, err_vld ? err_sev : SEV_NONE);
        st_d.field = st_q.field & ~clr_mask;
        st_d.pend  = merged;
        if (cmd_done) begin
            st_d.field = sev_merge(st_d.field, merged);
            st_d.pend  = SEV_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cmd_field = st_q.field;

    AST_SIG_WAIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |=> (st_q.field & ~$past(st_q.field)) == 2'b00); // R7

    AST_SIG_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.field != 2'b11); // R7

endmodule

// File: rtl/fecc_report.sv
module fecc_report
    import fecc_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_vld,
    input  logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_sec,
    input  logic              rd_ded,
    input  logic              rd_in_sig,
    input  logic              cmd_done,
    input  logic [3:0]        cfg_mode,
    input  logic              clr_wr,
    input  logic [12:0]       clr_bits,
    output logic [12:0]       status,
    output logic              irq,
    output logic              bus_err,
    output logic [ADDR_W-1:0] err_addr,
    output logic              err_bank,
    output logic [ADDR_W-1:0] fault_addr
);

    typedef struct packed {
        logic              int_pend;
        logic              err_bank;
        logic [ADDR_W-1:0] err_addr;
        logic              bus_err;
        logic [ADDR_W-1:0] fault_addr;
    } rep_st_t;

    rep_st_t st_d, st_q;

    logic [1:0]  rd_sev;
    logic [1:0]  sel_mode;
    logic        norm_err, sig_err;
    logic        rpt_int, rpt_exc, rec_vld;
    logic [1:0]  bank_field [NBANK];
    logic [1:0]  bank_clr   [NBANK];
    logic [1:0]  cmd_clr;
    logic [1:0]  cmd_field;
    logic        fields_clear_next;
    logic        unused_low_bits;

    // classify the incoming read
    always_comb begin
        rd_sev   = rd_ded ? SEV_DED : (rd_sec ? SEV_SEC : SEV_NONE);
        sel_mode = (rd_sev == SEV_DED) ? cfg_mode[3:2] : cfg_mode[1:0];
        norm_err = rd_vld && !rd_in_sig && (rd_sev != SEV_NONE);
        sig_err  = rd_vld &&  rd_in_sig && (rd_sev != SEV_NONE);
        rpt_int  = norm_err && (sel_mode == RPT_IRQ);
        rpt_exc  = norm_err && (sel_mode == RPT_EXC);
        rec_vld  = rpt_int || rpt_exc;
    end

    assign cmd_clr         = clr_wr ? clr_bits[CMD_LSB+1:CMD_LSB] : 2'b00;
    assign unused_low_bits = ^clr_bits[CMD_LSB-1:0];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int LSB = (b == 0) ? BANK0_LSB : BANK1_LSB;
        assign bank_clr[b] = clr_wr ? clr_bits[LSB+1:LSB] : 2'b00;
        fecc_bank_field u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_vld  (rec_vld && (rd_bank == b[0])),
            .set_sev  (rd_sev),
            .clr_mask (bank_clr[b]),
            .field    (bank_field[b])
        );
    end

    fecc_sig_track u_sig (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_vld   (sig_err),
        .err_sev   (rd_sev),
        .cmd_done  (cmd_done),
        .clr_mask  (cmd_clr),
        .cmd_field (cmd_field)
    );

    always_comb begin
        fields_clear_next = !rec_vld
                         && ((bank_field[0] & ~bank_clr[0]) == 2'b00)
                         && ((bank_field[1] & ~bank_clr[1]) == 2'b00);
        st_d         = st_q;
        st_d.bus_err = rpt_exc;
        if (rpt_exc)
            st_d.fault_addr = rd_addr;
        if (rpt_int) begin
            st_d.int_pend = 1'b1;
            if (!st_q.int_pend) begin
                st_d.err_addr = rd_addr;
                st_d.err_bank = rd_bank;
            end
        end else if (st_q.int_pend && fields_clear_next) begin
            st_d.int_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign status     = {bank_field[1], bank_field[0], cmd_field, 7'b0};
    assign irq        = st_q.int_pend;
    assign bus_err    = st_q.bus_err;
    assign err_addr   = st_q.err_addr;
    assign err_bank   = st_q.err_bank;
    assign fault_addr = st_q.fault_addr;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (!irq || ($stable(err_addr) && $stable(err_bank)))); // R4

    AST_BUS_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_vld && !rd_in_sig) |=> !bus_err); // R6

    AST_SIG_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && rd_in_sig) |=> (!bus_err && $stable(fault_addr))); // R7

    AST_OFF_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 4'h0 && !clr_wr) |=> $stable(status[12:9])); // R3

endmodule

// File: tb/fecc_report_tb.sv
module fecc_report_tb;

    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_vld = 1'b0, rd_bank = 1'b0, rd_sec = 1'b0, rd_ded = 1'b0;
    logic              rd_in_sig = 1'b0, cmd_done = 1'b0, clr_wr = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [3:0]        cfg_mode = 4'h0;
    logic [12:0]       clr_bits = '0;
    logic [12:0]       status;
    logic              irq, bus_err, err_bank;
    logic [ADDR_W-1:0] err_addr, fault_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fecc_report #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_bank(rd_bank),
        .rd_addr(rd_addr), .rd_sec(rd_sec), .rd_ded(rd_ded),
        .rd_in_sig(rd_in_sig), .cmd_done(cmd_done), .cfg_mode(cfg_mode),
        .clr_wr(clr_wr), .clr_bits(clr_bits), .status(status), .irq(irq),
        .bus_err(bus_err), .err_addr(err_addr), .err_bank(err_bank),
        .fault_addr(fault_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle of inputs at a negedge, return to idle at the next negedge
    task automatic step(input logic rv, input logic bk, input logic [ADDR_W-1:0] ad,
                        input logic sec, input logic ded, input logic sig,
                        input logic done, input logic cw, input logic [12:0] cb);
        @(negedge clk);
        rd_vld = rv; rd_bank = bk; rd_addr = ad; rd_sec = sec; rd_ded = ded;
        rd_in_sig = sig; cmd_done = done; clr_wr = cw; clr_bits = cb;
        @(negedge clk);
        rd_vld = 0; rd_sec = 0; rd_ded = 0; rd_in_sig = 0; cmd_done = 0;
        clr_wr = 0; clr_bits = '0;
    endtask

    task automatic rd(input logic bk, input logic [ADDR_W-1:0] ad, input logic sec, input logic ded);
        step(1, bk, ad, sec, ded, 0, 0, 0, '0);
    endtask

    task automatic clr(input logic [12:0] m);
        step(0, 0, '0, 0, 0, 0, 0, 1, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status", status, 0);
        chk("R1 irq", irq, 0);
        chk("R1 bus_err", bus_err, 0);
        chk("R1 err_addr", err_addr, 0);
        chk("R1 err_bank", err_bank, 0);
        chk("R1 fault_addr", fault_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: every mode word x bank x severity combination
        for (int m = 0; m < 16; m++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 1; s < 4; s++) begin
                    logic [1:0] sev, mode, expf;
                    logic [ADDR_W-1:0] ad;
                    clr(13'h1F80);
                    @(negedge clk);
                    cfg_mode = m[3:0];
                    sev  = s[1] ? 2'b10 : 2'b01;
                    mode = s[1] ? m[3:2] : m[1:0];
                    expf = (mode == 2'b01 || mode == 2'b10) ? sev : 2'b00;
                    ad   = ADDR_W'(32'h100 + m * 8 + b * 4 + s);
                    rd(b[0], ad, s[0], s[1]);
                    chk("R2 R3 target field", b ? status[12:11] : status[10:9], expf);
                    chk("R3 other field", b ? status[10:9] : status[12:11], 0);
                    chk("R3 R4 irq", irq, mode == 2'b01);
                    chk("R3 R6 bus_err", bus_err, mode == 2'b10);
                    if (mode == 2'b10) chk("R6 fault_addr", fault_addr, ad);
                    if (mode == 2'b01) begin
                        chk("R4 err_addr", err_addr, ad);
                        chk("R4 err_bank", err_bank, b);
                    end
                    @(negedge clk);
                    chk("R6 one-cycle pulse", bus_err, 0);
                end
            end
        end

        // override ordering and first-address hold
        clr(13'h1F80);
        cfg_mode = 4'b0101;
        rd(0, 18'h0AAA, 1, 0);
        chk("R2 single code", status[10:9], 2'b01);
        rd(0, 18'h0BBB, 0, 1);
        chk("R2 double overrides", status[10:9], 2'b10);
        chk("R4 first address held", err_addr, 18'h0AAA);
        rd(0, 18'h0CCC, 1, 0);
        chk("R2 no downgrade", status[10:9], 2'b10);
        clr(13'h0400);
        chk("R8 w1c bank0", status[10:9], 0);
        chk("R5 irq falls", irq, 0);
        rd(1, 18'h0DDD, 1, 0);
        chk("R5 new capture addr", err_addr, 18'h0DDD);
        chk("R5 new capture bank", err_bank, 1);
        rd(0, 18'h0EEE, 1, 0);
        chk("R4 held while pending", err_addr, 18'h0DDD);
        clr(13'h1800);
        chk("R5 irq stays with bank0 set", irq, 1);
        clr(13'h0000);
        chk("R8 zero mask no effect", status[10:9], 2'b01);
        clr(13'h0600);
        chk("R5 irq clear after all", irq, 0);

        // set wins over same-cycle clear
        step(1, 0, 18'h0123, 0, 1, 0, 0, 1, 13'h0600);
        chk("R8 set beats clear", status[10:9], 2'b10);
        clr(13'h1F80);

        // signature-command errors
        cfg_mode = 4'b1010;
        step(1, 1, 18'h0777, 0, 1, 1, 0, 0, '0);
        chk("R7 no bus_err", bus_err, 0);
        chk("R7 held back", status, 0);
        chk("R7 no irq", irq, 0);
        step(1, 0, 18'h0778, 1, 0, 1, 0, 0, '0);
        chk("R7 still held", status[8:7], 0);
        step(0, 0, '0, 0, 0, 0, 1, 0, '0);
        chk("R7 merged on done", status[8:7], 2'b10);
        chk("R7 banks untouched", status[12:9], 0);
        clr(13'h0180);
        chk("R8 w1c cmd field", status[8:7], 0);
        cfg_mode = 4'b0000;
        step(1, 0, 18'h0779, 1, 0, 1, 1, 0, '0);
        chk("R7 same-cycle error on done", status[8:7], 2'b01);
        step(0, 0, '0, 0, 0, 0, 1, 0, '0);
        chk("R7 pending emptied", status[8:7], 2'b01);
        chk("R8 low bits zero", status[6:0], 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule